// File: doc/BRIEF.md
# Single-Register Synchronous Serial Port

This block moves one byte at a time over a three-wire synchronous serial link: a shift clock, a serial data output and a serial data input. A single byte-wide shift register serves both directions. Each bit that leaves on the data output is replaced by a bit taken from the data input, so after one full transfer the register holds the received byte. A bit counter tracks the position in the byte.

A select pin picks the source of the shift clock. With the internal source, the block divides the system clock, drives the shift clock pin and produces exactly one byte's worth of pulses. With the external source, the shift clock comes from a link partner and is synchronized to the system clock before its edges are detected. Loading a byte through the write port starts a transfer and resets the bit counter. A done flag and a one-cycle interrupt pulse mark the end of each byte.

The write port uses a valid/ready handshake. `wr_ready` is always high, so a write is accepted in every cycle in which `wr_valid` is high and is never stalled. A write that arrives during a transfer aborts that transfer and starts a new one.

Top module: `sio_shift_port`

## Requirements
- R1: `wr_ready` is always 1. A cycle with `wr_valid` high loads `wr_data` into the register, so `rd_data` shows it one cycle later. The same write clears `done` and restarts the bit count. This holds even while an external `sclk_in` is low.
- R2: With `clk_sel`=0 (internal), a write produces exactly 8 low pulses on `sclk_out`. Each level lasts `DIV_HALF` system clocks, and `sclk_out` idles at 1. `sclk_oe` is 1 when internal and 0 when external (`clk_sel`=1).
- R3: Data moves LSB first. `sout` changes on the falling edges of the shift clock. `sin` is sampled on the rising edges and enters at bit 7. After 8 rising edges, `rd_data` holds the received bits, with the first bit at bit 0.
- R4: The 8th rising edge after a write sets `done`, and `irq` is high for exactly one system clock at that moment.
- R5: With the internal clock, `sout_oe` is 0 before the first write and after a transfer completes.
- R6: With the external clock, `sout_oe` stays 1, and after completion `sout` keeps the level of the original bit 7.
- R7: With the external clock, further `sclk_in` pulses after completion keep shifting the register and `sout`. `done` stays 1 and no further `irq` occurs.
- R8: A write during a transfer restarts the count, so `done` rises only after 8 full pulses that follow the write.
- R9: When a write and a detected shift-clock edge fall in the same cycle, the write takes effect and the edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | Shift clock source: 0 internal, 1 external |
| wr_valid | input | 1 | Write request |
| wr_data | input | 8 | Byte to load |
| wr_ready | output | 1 | Write accepted (always 1) |
| rd_data | output | 8 | Current shift register contents |
| done | output | 1 | Transfer complete flag |
| irq | output | 1 | One-cycle completion pulse |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Internally generated shift clock |
| sclk_oe | output | 1 | Drive enable for sclk_out |
| sin | input | 1 | Serial data in |
| sout | output | 1 | Serial data out |
| sout_oe | output | 1 | Drive enable for sout |

## Verification
A register write and a synchronized rising edge of the external clock can both occur in the same system cycle. Both would change the shift register and the bit count. The bench provokes this collision by raising `sclk_in` and asserting the write exactly two system clocks later, which is the cycle in which the synchronizer presents the edge. It judges the result in two ways. First, `rd_data` must equal the written byte, unshifted. Second, `done` must stay low through seven further pulses and rise only on the eighth.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;
endpackage

// File: rtl/sio_clk_src.sv
module sio_clk_src
  import sio_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_src_e src,
  input  logic     busy,
  input  logic     restart,
  input  logic     sclk_in,
  output logic     rise,
  output logic     fall,
  output logic     sclk_int
);
  localparam int DW = (DIV_HALF > 2) ? $clog2(DIV_HALF) : 1;

  logic [DW-1:0]       div_q;
  logic                sclk_q;
  logic [SYNC_LEN-1:0] sync_q;
  logic                prev_q;
  logic                tick, int_rise, int_fall, ext_rise, ext_fall, ext_lvl;

  // internal divider: runs only while a transfer is in flight, idles high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else if (restart || !busy) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else if (div_q == DW'(DIV_HALF - 1)) begin
      div_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick     = busy && !restart && (div_q == DW'(DIV_HALF - 1));
  assign int_fall = tick && sclk_q;
  assign int_rise = tick && !sclk_q;

  // external clock: synchronizer chain then edge detect
  generate
    if (SYNC_LEN == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sclk_in;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_LEN-2:0], sclk_in};
      end
    end
  endgenerate

  assign ext_lvl = sync_q[SYNC_LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= ext_lvl;
  end

  assign ext_rise = ext_lvl && !prev_q;
  assign ext_fall = !ext_lvl && prev_q;

  assign rise     = (src == SRC_EXT) ? ext_rise : int_rise;
  assign fall     = (src == SRC_EXT) ? ext_fall : int_fall;
  assign sclk_int = sclk_q;

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> sclk_q); // R2
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall)); // R3
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rise,
  input  logic              fall,
  input  logic              sin,
  output logic [DATA_W-1:0] sreg,
  output logic              sout,
  output logic              busy,
  output logic              done,
  output logic              irq
);
  localparam int CW = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  logic [CW-1:0] cnt_q;
  logic          last_bit;

  assign last_bit = (cnt_q == CW'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '0;
      sout  <= 1'b1;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (wr) begin
        // a write wins over any edge seen in the same cycle
        sreg  <= wr_data;
        cnt_q <= '0;
        busy  <= 1'b1;
        done  <= 1'b0;
      end else begin
        if (fall) sout <= sreg[0];
        if (rise) begin
          sreg <= {sin, sreg[DATA_W-1:1]};
          if (busy) begin
            cnt_q <= cnt_q + 1'b1;
            if (last_bit) begin
              busy  <= 1'b0;
              done  <= 1'b1;
              irq   <= 1'b1;
              cnt_q <= '0;
            end
          end
        end
      end
    end
  end

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (sreg == $past(wr_data))); // R1
  AST_WRITE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !done); // R1
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R4
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy)); // R4
endmodule

// File: rtl/sio_shift_port.sv
module sio_shift_port #(
  parameter int DATA_W   = 8,
  parameter int DIV_HALF = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_sel,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              irq,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sin,
  output logic              sout,
  output logic              sout_oe
);
  import sio_pkg::*;

  clk_src_e src;
  logic     busy, rise, fall, wr;

  assign src      = clk_src_e'(clk_sel);
  assign wr_ready = 1'b1;
  assign wr       = wr_valid && wr_ready;

  sio_clk_src #(.DIV_HALF(DIV_HALF), .SYNC_LEN(SYNC_LEN)) u_clk (
    .clk(clk), .rst_n(rst_n), .src(src), .busy(busy), .restart(wr),
    .sclk_in(sclk_in), .rise(rise), .fall(fall), .sclk_int(sclk_out)
  );

  sio_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .wr(wr), .wr_data(wr_data), .rise(rise),
    .fall(fall), .sin(sin), .sreg(rd_data), .sout(sout), .busy(busy),
    .done(done), .irq(irq)
  );

  assign sclk_oe = (src == SRC_INT);
  assign sout_oe = (src == SRC_EXT) ? 1'b1 : busy;

  AST_HIZ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_sel && done) |-> !sout_oe); // R5
  AST_EXT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel |-> (sout_oe && !sclk_oe)); // R6
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready); // R1
endmodule

// File: tb/test_sio_shift_port.sv
module test_sio_shift_port;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_sel = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready;
  logic [7:0] rd_data;
  logic       done, irq;
  logic       sclk_in = 1'b1;
  logic       sclk_out, sclk_oe;
  logic       sin = 1'b0;
  logic       sout, sout_oe;

  int checks = 0;
  int fails = 0;
  int irq_total = 0;

  always #10 clk = ~clk;

  sio_shift_port i_sio_shift_port (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .rd_data(rd_data), .done(done),
    .irq(irq), .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .sin(sin), .sout(sout), .sout_oe(sout_oe)
  );

  always @(negedge clk) if (rst_n && irq) irq_total++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic ext_pulse(input logic b, output logic seen);
    @(negedge clk);
    sclk_in = 1'b0;
    sin     = b;
    repeat (HALF) @(negedge clk);
    seen    = sout;
    sclk_in = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "wr_ready", wr_ready, 1);
    chk("R4", "done at reset", done, 0);
    chk("R5", "sout_oe before write", sout_oe, 0);
    chk("R2", "sclk_out idle", sclk_out, 1);
    chk("R2", "sclk_oe internal", sclk_oe, 1);
  endtask

  task automatic t_internal(input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] cap = '0;
    int k = 0;
    int pulses = 0;
    int irq0 = irq_total;
    logic last = 1'b1;
    do_write(tx);
    chk("R1", "load", rd_data, tx);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (last && !sclk_out) begin
        pulses++;
        if (k < 8) sin = rx[k];
      end
      if (!last && sclk_out && k < 8) begin
        cap[k] = sout;
        k++;
      end
      last = sclk_out;
    end
    chk("R2", "pulse count", pulses, 8);
    chk("R2", "sclk idle after", sclk_out, 1);
    chk("R3", "sent LSB first", cap, tx);
    chk("R3", "received byte", rd_data, rx);
    chk("R4", "done", done, 1);
    chk("R4", "irq cycles", irq_total - irq0, 1);
    chk("R5", "sout_oe after done", sout_oe, 0);
  endtask

  task automatic t_external(input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] cap = '0;
    logic s;
    int irq0;
    @(negedge clk);
    clk_sel = 1'b1;
    @(negedge clk);
    chk("R2", "sclk_oe external", sclk_oe, 0);
    irq0 = irq_total;
    do_write(tx);
    for (int i = 0; i < 8; i++) begin
      ext_pulse(rx[i], s);
      cap[i] = s;
    end
    chk("R3", "ext sent", cap, tx);
    chk("R3", "ext received", rd_data, rx);
    chk("R4", "ext done", done, 1);
    chk("R6", "sout holds bit 7", sout, tx[7]);
    chk("R6", "sout_oe ext", sout_oe, 1);
    ext_pulse(1'b1, s);
    chk("R7", "sout after extra pulse", s, rx[0]);
    chk("R7", "shift continues", rd_data, {1'b1, rx[7:1]});
    chk("R7", "done stays", done, 1);
    chk("R7", "single irq", irq_total - irq0, 1);
  endtask

  task automatic t_write_low;
    @(negedge clk);
    sclk_in = 1'b0;
    repeat (HALF) @(negedge clk);
    do_write(8'h5A);
    chk("R1", "load with sclk low", rd_data, 8'h5A);
    chk("R1", "done cleared", done, 0);
    sclk_in = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic t_restart;
    logic s;
    do_write(8'h11);
    for (int i = 0; i < 3; i++) ext_pulse(1'b0, s);
    do_write(8'h96);
    for (int i = 0; i < 7; i++) ext_pulse(1'b1, s);
    chk("R8", "no done after 7", done, 0);
    ext_pulse(1'b1, s);
    chk("R8", "done after 8", done, 1);
    chk("R8", "received", rd_data, 8'hFF);
  endtask

  task automatic t_collide;
    logic s;
    @(negedge clk);
    sclk_in = 1'b0;
    repeat (HALF) @(negedge clk);
    sclk_in = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = 8'hC3;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R9", "write wins over edge", rd_data, 8'hC3);
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 7; i++) ext_pulse(1'b0, s);
    chk("R9", "edge not counted", done, 0);
    ext_pulse(1'b0, s);
    chk("R9", "done on 8th", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_internal(8'hA5, 8'h3C);
    t_internal(8'h81, 8'hE7);
    t_external(8'h6B, 8'hD2);
    t_write_low();
    t_restart();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule